// File: doc/BRIEF.md
# Product-Term Array with Regional Foldback

This block is the logic-generation front end of a 32-macrocell programmable logic device. It gathers the dedicated pin values and the buried feedback of every macrocell into one global signal set, and presents each signal in true and complemented form. Every product term of every macrocell sees that whole bus. A programmable connection mask per product term selects which bus lines are ANDed together.

Each macrocell owns five local product terms. It also drives one foldback line, which is the inverse of one of its own product terms chosen by a 3-bit selector. The macrocells are split into regions of sixteen. The foldback lines of a region form a regional bus that every macrocell in that region can reach. Each macrocell's sum term ORs any chosen subset of its five local terms and its region's sixteen foldbacks, so one sum can gather up to 21 terms. The array is purely combinational. Register behaviour is handled downstream.

Top module: `pta_array`

## Requirements
- R1: Signal s of the global set is pin s for s below N_PIN, and is feedback s-N_PIN otherwise. Bus bit 2s carries signal s true and bus bit 2s+1 carries it complemented. With the defaults (2 pins, 32 macrocells) the bus is 68 bits wide.
- R2: Product term t of macrocell m is the AND of every bus bit whose mask bit is 1. Its mask is `pt_mask_i[(m*5+t)*68 +: 68]`, with mask bit b connecting bus bit b. The term appears on `pterm_o[m*5+t]`.
- R3: A product term with no mask bit set evaluates to 1.
- R4: A product term that connects both polarities of any one signal evaluates to 0 for every input value.
- R5: `fold_o[m]` is the inverse of the local product term of macrocell m whose index t (0..4) equals `fold_sel_i[m*3 +: 3]`.
- R6: A foldback selector value of 5, 6 or 7 drives `fold_o[m]` to 0.
- R7: Macrocell m belongs to region m/16. Sum mask bit 5+j selects the foldback of the macrocell at position j of that region, and foldbacks of the other region have no effect on its sum.
- R8: `sum_o[m]` is the OR of the local product terms selected by sum mask bits 0..4 of `sum_mask_i[m*21 +: 21]` and of the regional foldbacks selected by bits 5..20. This gives up to 21 sources.
- R9: A sum term with no mask bit set evaluates to 0.
- R10: All outputs follow the inputs combinationally, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pin_i | input | N_PIN | Dedicated pin values |
| fb_i | input | N_MC | Buried feedback, one bit per macrocell |
| pt_mask_i | input | N_MC*N_PT*BUS_W | Product-term connection masks |
| fold_sel_i | input | N_MC*SEL_W | Foldback source selector per macrocell |
| sum_mask_i | input | N_MC*(N_PT+REGION) | Sum-term connection masks |
| pterm_o | output | N_MC*N_PT | All local product terms |
| fold_o | output | N_MC | Foldback lines; region r occupies bits r*16 upward |
| sum_o | output | N_MC | Sum term per macrocell |

## Verification
The embedded checks watch four things on every evaluation: that an empty product term stays high, that opposed polarities force a term low, that each foldback mirrors the inverse of its selected term or is idle for out-of-range selectors, and that an empty sum stays low while any selected active source raises it. Other properties can only be shown by the bench. These are the mapping of pins and feedback onto bus positions, confinement of foldback reach to a single region, and full agreement with an independent model over sparse, dense and forced-true random masks.

// File: rtl/pta_pkg.sv
package pta_pkg;
    localparam int DEF_PINS   = 2;
    localparam int DEF_MCELLS = 32;
    localparam int DEF_TERMS  = 5;
    localparam int DEF_REGION = 16;

    // Width of a selector able to address n items (at least one bit).
    function automatic int sel_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pta_global_bus.sv
module pta_global_bus #(
    parameter int N_PIN = 2,
    parameter int N_MC  = 32
) (
    input  logic [N_PIN-1:0]            pin_i,
    input  logic [N_MC-1:0]             fb_i,
    output logic [2*(N_PIN+N_MC)-1:0]   bus_o
);
    localparam int N_SIG = N_PIN + N_MC;

    logic [N_SIG-1:0] sig_all;
    assign sig_all = {fb_i, pin_i};

    // Each signal occupies a true/complement pair of adjacent bus lines.
    for (genvar s = 0; s < N_SIG; s++) begin : g_pair
        assign bus_o[2*s]   = sig_all[s];
        assign bus_o[2*s+1] = ~sig_all[s];
    end
endmodule

// File: rtl/pta_pterm.sv
module pta_pterm #(
    parameter int BUS_W = 68
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [BUS_W-1:0] mask_i,
    output logic             pt_o
);
    // Unconnected lines are forced to 1 so they do not affect the AND.
    assign pt_o = &(bus_i | ~mask_i);

    always_comb begin
        if (mask_i == '0) begin
            assert_empty_pterm_high_R3: assert (pt_o)
                else $error("empty product term is low");
        end
        for (int k = 0; k < BUS_W/2; k++) begin
            if (mask_i[2*k] && mask_i[2*k+1]) begin
                assert_opposed_pair_low_R4: assert (!pt_o)
                    else $error("term with opposed pair %0d is high", k);
            end
        end
    end
endmodule

// File: rtl/pta_mc_terms.sv
module pta_mc_terms #(
    parameter int BUS_W = 68,
    parameter int N_PT  = 5,
    parameter int SEL_W = 3
) (
    input  logic [BUS_W-1:0]      bus_i,
    input  logic [N_PT*BUS_W-1:0] mask_i,
    input  logic [SEL_W-1:0]      fold_sel_i,
    output logic [N_PT-1:0]       pt_o,
    output logic                  fold_o
);
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        pta_pterm #(.BUS_W(BUS_W)) i_term (
            .bus_i  (bus_i),
            .mask_i (mask_i[t*BUS_W +: BUS_W]),
            .pt_o   (pt_o[t])
        );
    end

    // Foldback: inverse of the chosen local term, idle low when out of range.
    always_comb begin
        fold_o = 1'b0;
        for (int t = 0; t < N_PT; t++) begin
            if (fold_sel_i == SEL_W'(t)) fold_o = ~pt_o[t];
        end
    end
endmodule

// File: rtl/pta_sum.sv
module pta_sum #(
    parameter int N_PT   = 5,
    parameter int REGION = 16
) (
    input  logic [N_PT-1:0]        pt_i,
    input  logic [REGION-1:0]      fold_i,
    input  logic [N_PT+REGION-1:0] mask_i,
    output logic                   sum_o
);
    localparam int SUM_W = N_PT + REGION;

    logic [SUM_W-1:0] src;
    assign src   = {fold_i, pt_i};
    assign sum_o = |(src & mask_i);

    always_comb begin
        if (mask_i == '0) begin
            assert_empty_sum_low_R9: assert (!sum_o)
                else $error("empty sum term is high");
        end
        for (int k = 0; k < SUM_W; k++) begin
            if (mask_i[k] && src[k]) begin
                assert_sum_covers_R8: assert (sum_o)
                    else $error("sum low although source %0d is active", k);
            end
        end
    end
endmodule

// File: rtl/pta_array.sv
module pta_array
    import pta_pkg::*;
#(
    parameter int N_PIN  = DEF_PINS,
    parameter int N_MC   = DEF_MCELLS,
    parameter int N_PT   = DEF_TERMS,
    parameter int REGION = DEF_REGION
) (
    input  logic [N_PIN-1:0]                                 pin_i,
    input  logic [N_MC-1:0]                                  fb_i,
    input  logic [N_MC*N_PT*2*(N_PIN+N_MC)-1:0]              pt_mask_i,
    input  logic [N_MC*sel_width(N_PT)-1:0]                  fold_sel_i,
    input  logic [N_MC*(N_PT+REGION)-1:0]                    sum_mask_i,
    output logic [N_MC*N_PT-1:0]                             pterm_o,
    output logic [N_MC-1:0]                                  fold_o,
    output logic [N_MC-1:0]                                  sum_o
);
    localparam int BUS_W = 2*(N_PIN+N_MC);
    localparam int SEL_W = sel_width(N_PT);
    localparam int SUM_W = N_PT + REGION;

    logic [BUS_W-1:0] bus;

    pta_global_bus #(.N_PIN(N_PIN), .N_MC(N_MC)) i_bus (
        .pin_i (pin_i),
        .fb_i  (fb_i),
        .bus_o (bus)
    );

    // Stage 1: local product terms and foldback per macrocell.
    for (genvar m = 0; m < N_MC; m++) begin : g_terms
        pta_mc_terms #(.BUS_W(BUS_W), .N_PT(N_PT), .SEL_W(SEL_W)) i_terms (
            .bus_i      (bus),
            .mask_i     (pt_mask_i[m*N_PT*BUS_W +: N_PT*BUS_W]),
            .fold_sel_i (fold_sel_i[m*SEL_W +: SEL_W]),
            .pt_o       (pterm_o[m*N_PT +: N_PT]),
            .fold_o     (fold_o[m])
        );

        always_comb begin
            if (int'(fold_sel_i[m*SEL_W +: SEL_W]) >= N_PT) begin
                assert_fold_idle_R6: assert (!fold_o[m])
                    else $error("macrocell %0d foldback active with idle selector", m);
            end
            for (int t = 0; t < N_PT; t++) begin
                if (fold_sel_i[m*SEL_W +: SEL_W] == SEL_W'(t)) begin
                    assert_fold_inverse_R5: assert (fold_o[m] != pterm_o[m*N_PT+t])
                        else $error("macrocell %0d foldback not inverse of term %0d", m, t);
                end
            end
        end
    end

    // Stage 2: sums over local terms plus the macrocell's own regional bus.
    for (genvar m = 0; m < N_MC; m++) begin : g_sums
        localparam int BASE = (m / REGION) * REGION;
        pta_sum #(.N_PT(N_PT), .REGION(REGION)) i_sum (
            .pt_i   (pterm_o[m*N_PT +: N_PT]),
            .fold_i (fold_o[BASE +: REGION]),
            .mask_i (sum_mask_i[m*SUM_W +: SUM_W]),
            .sum_o  (sum_o[m])
        );
    end
endmodule

// File: tb/test_pta_array.sv
module test_pta_array;
    import pta_pkg::*;

    localparam int N_PIN  = DEF_PINS;
    localparam int N_MC   = DEF_MCELLS;
    localparam int N_PT   = DEF_TERMS;
    localparam int REGION = DEF_REGION;
    localparam int BUS_W  = 2*(N_PIN+N_MC);
    localparam int SEL_W  = 3;
    localparam int SUM_W  = N_PT + REGION;
    localparam int PTM_W  = N_MC*N_PT*BUS_W;

    typedef struct packed {
        logic [31:0] fb;
        logic [1:0]  pins;
        logic [15:0] den;   // one connection in den on average
        logic        hit;   // term 0 of each macrocell connects only true lines
    } row_t;

    localparam int N_ROWS = 8;
    localparam row_t ROWS [N_ROWS] = '{
        '{32'h0000_0000, 2'b00, 16'd40,  1'b0},
        '{32'hFFFF_FFFF, 2'b11, 16'd40,  1'b1},
        '{32'hA5A5_5A5A, 2'b01, 16'd20,  1'b1},
        '{32'h1234_8765, 2'b10, 16'd68,  1'b0},
        '{32'h0F0F_F0F0, 2'b11, 16'd200, 1'b0},
        '{32'hDEAD_BEEF, 2'b00, 16'd8,   1'b1},
        '{32'h8000_0001, 2'b01, 16'd100, 1'b1},
        '{32'h7FFE_0001, 2'b10, 16'd30,  1'b0}
    };

    logic                    clk = 1'b0;
    logic [N_PIN-1:0]        pin;
    logic [N_MC-1:0]         fb;
    logic [PTM_W-1:0]        ptm;
    logic [N_MC*SEL_W-1:0]   fsel;
    logic [N_MC*SUM_W-1:0]   smask;
    logic [N_MC*N_PT-1:0]    pterm;
    logic [N_MC-1:0]         fold;
    logic [N_MC-1:0]         sum;

    logic [N_MC*N_PT-1:0]    exp_pt;
    logic [N_MC-1:0]         exp_fold;
    logic [N_MC-1:0]         exp_sum;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    pta_array i_pta_array (
        .pin_i      (pin),
        .fb_i       (fb),
        .pt_mask_i  (ptm),
        .fold_sel_i (fsel),
        .sum_mask_i (smask),
        .pterm_o    (pterm),
        .fold_o     (fold),
        .sum_o      (sum)
    );

    task automatic check(string req, logic [159:0] act, logic [159:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Independent model of the bus line b (R1).
    function automatic logic bus_bit(int b);
        int   s = b / 2;
        logic v = (s < N_PIN) ? pin[s] : fb[s-N_PIN];
        return (b % 2 == 1) ? ~v : v;
    endfunction

    task automatic model();
        for (int m = 0; m < N_MC; m++) begin
            for (int t = 0; t < N_PT; t++) begin
                logic e = 1'b1;
                for (int b = 0; b < BUS_W; b++)
                    if (ptm[(m*N_PT+t)*BUS_W+b] && !bus_bit(b)) e = 1'b0;
                exp_pt[m*N_PT+t] = e;
            end
        end
        for (int m = 0; m < N_MC; m++) begin
            int sel = int'(fsel[m*SEL_W +: SEL_W]);
            exp_fold[m] = (sel < N_PT) ? ~exp_pt[m*N_PT+sel] : 1'b0;
        end
        for (int m = 0; m < N_MC; m++) begin
            int   base = (m / REGION) * REGION;
            logic s = 1'b0;
            for (int t = 0; t < N_PT; t++)
                if (smask[m*SUM_W+t] && exp_pt[m*N_PT+t]) s = 1'b1;
            for (int j = 0; j < REGION; j++)
                if (smask[m*SUM_W+N_PT+j] && exp_fold[base+j]) s = 1'b1;
            exp_sum[m] = s;
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_all();
        ptm = '0; fsel = '0; smask = '0; pin = '0; fb = '0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : main
        clear_all();
        settle();

        // Table walk: random masks checked against the model (R1, R2, R5, R7, R8, R10).
        for (int r = 0; r < N_ROWS; r++) begin
            pin = ROWS[r].pins;
            fb  = ROWS[r].fb;
            for (int k = 0; k < PTM_W; k++)
                ptm[k] = (($urandom % ROWS[r].den) == 0);
            if (ROWS[r].hit)
                for (int m = 0; m < N_MC; m++)
                    for (int b = 0; b < BUS_W; b++)
                        ptm[m*N_PT*BUS_W+b] = ptm[m*N_PT*BUS_W+b] & bus_bit(b);
            for (int m = 0; m < N_MC; m++) fsel[m*SEL_W +: SEL_W] = 3'($urandom % 8);
            for (int k = 0; k < N_MC*SUM_W; k++) smask[k] = (($urandom % 4) == 0);
            #1;
            model();
            #1;
            check("R2 table product terms", 160'(pterm), 160'(exp_pt));
            check("R5 table foldbacks", 160'(fold), 160'(exp_fold));
            check("R8 table sums", 160'(sum), 160'(exp_sum));
            settle();
        end

        // R3 / R9: empty masks.
        clear_all();
        settle();
        check("R3 empty terms high", 160'(pterm), {160{1'b0}} | {N_MC*N_PT{1'b1}});
        check("R9 empty sums low", 160'(sum), 160'(0));
        check("R5 folds of high terms low", 160'(fold), 160'(0));

        // R1 / R2: single-polarity connections on fb[3] (signal 5) and fb[31] (signal 33).
        ptm[(0*N_PT+2)*BUS_W + 10] = 1'b1;
        ptm[(0*N_PT+3)*BUS_W + 11] = 1'b1;
        ptm[(0*N_PT+4)*BUS_W + 67] = 1'b1;
        // R4: both polarities of signal 5 on term 1.
        ptm[(0*N_PT+1)*BUS_W + 10] = 1'b1;
        ptm[(0*N_PT+1)*BUS_W + 11] = 1'b1;
        fb = 32'h0000_0008;
        settle();
        check("R2 true line follows fb3", 160'(pterm[2]), 160'(1));
        check("R2 complement line of fb3", 160'(pterm[3]), 160'(0));
        check("R1 fb31 complement at bus bit 67", 160'(pterm[4]), 160'(1));
        check("R4 opposed pair low (fb3=1)", 160'(pterm[1]), 160'(0));
        fb = 32'h8000_0000;
        settle();
        check("R2 true line follows fb3 low", 160'(pterm[2]), 160'(0));
        check("R1 fb31 high drops complement term", 160'(pterm[4]), 160'(0));
        check("R4 opposed pair low (fb3=0)", 160'(pterm[1]), 160'(0));

        // R7: foldback of macrocell 31 reaches macrocell 20, not macrocell 4.
        clear_all();
        ptm[(31*N_PT+0)*BUS_W + 0] = 1'b1;          // pin0 true
        smask[20*SUM_W + N_PT + 15] = 1'b1;
        smask[4*SUM_W + N_PT + 15]  = 1'b1;
        settle();
        check("R5 fold31 raised", 160'(fold), 160'(32'h8000_0000));
        check("R7 region 1 sum sees fold31", 160'(sum[20]), 160'(1));
        check("R7 region 0 sum unaffected", 160'(sum[4]), 160'(0));

        // R6: out-of-range selectors idle the foldback.
        for (int v = 5; v < 8; v++) begin
            fsel[31*SEL_W +: SEL_W] = 3'(v);
            settle();
            check($sformatf("R6 selector %0d fold idle", v), 160'(fold[31]), 160'(0));
            check("R6 idle fold leaves sum low", 160'(sum[20]), 160'(0));
        end

        // R8: macrocell 7 with all 21 sources enabled.
        clear_all();
        for (int t = 0; t < N_PT; t++) ptm[(7*N_PT+t)*BUS_W + 2] = 1'b1;  // pin1 true
        ptm[(9*N_PT+0)*BUS_W + 0] = 1'b1;                                 // pin0 true
        fsel[7*SEL_W +: SEL_W] = 3'd7;
        smask[7*SUM_W +: SUM_W] = '1;
        settle();
        check("R8 sum via foldback of macrocell 9", 160'(sum[7]), 160'(1));
        pin = 2'b01;
        settle();
        check("R8 no source active", 160'(sum[7]), 160'(0));
        pin = 2'b11;
        settle();
        check("R8 sum via local terms", 160'(sum[7]), 160'(1));

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule